// File: doc/BRIEF.md
# Shared SPI Data FIFO

A 64-byte data buffer that one channel at a time of a multi-channel SPI controller may borrow. Each channel offers a transmit-buffer enable bit and a receive-buffer enable bit. If exactly one channel has either bit set and that channel is enabled, the buffer serves that channel. If bits are set on more than one channel, the buffer stays idle for every channel. When the owner uses a single direction, that direction gets the whole store. When it uses both, the store is cut into two 32-byte halves.

Occupancy is kept in bytes. Each SPI word takes 1, 2 or 4 bytes, chosen from the owner's word length. The transmit side raises an almost-empty flag when its free space reaches a byte threshold. The receive side raises an almost-full flag when its held bytes reach a byte threshold. The host or DMA side pushes transmit words and pops receive words. The shift engine pops transmit words and pushes receive words. Each push or pop moves one whole word in a single cycle. Pop data is shown ahead of time: the word at the head appears on the pop data port before the pop is asked for, and it is consumed on the clock edge where the pop is accepted.

Top module: `spi_shared_fifo`

## Requirements
- R1: The buffer is active (`fifo_active`=1) exactly when one channel has its transmit or receive buffer bit set and that channel's `ch_en` bit is 1. `owner_ch` then gives that channel's index.
- R2: If buffer bits are set on two or more channels, the buffer is inactive. Every push and pop is refused, both directions report empty, and both threshold flags are 0.
- R3: With one direction enabled, that direction holds 64 bytes. With both enabled, each direction holds 32 bytes.
- R4: Bytes per word come from the owner's word length field (5 bits, the bit count itself). Lengths 3 to 7 take 1 byte, 8 to 15 take 2 bytes, and 16 to 31 take 4 bytes. A region's capacity in words is its byte size divided by that count.
- R5: Words leave in the order they entered. Each keeps its low 1, 2 or 4 bytes, stored lowest byte first, and its unused upper bytes are returned as 0.
- R6: A push is refused (`*_push_ok`=0) when the free space is smaller than one word. A pop is refused when the held bytes are fewer than one word. A refused request changes nothing.
- R7: Per direction, `*_full` is 1 when the held bytes equal the region size, and `*_empty` is 1 when no bytes are held.
- R8: `tx_almost_empty` is 1 when the transmit direction is active and its free bytes are at least `thr_tx_ae`+1.
- R9: `rx_almost_full` is 1 when the receive direction is active and its held bytes are at least `thr_rx_af`+1.
- R10: Any change of the buffer enable bits, of the owner's `ch_en`, or of the owner's word length empties both directions. In the cycle of the change, pushes and pops are refused.
- R11: A direction that is not enabled, or a buffer that is inactive, refuses its pushes and pops. It reports empty, not full, with its flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_tx_fifo_en | input | NUM_CH | Per-channel request for the buffer in the transmit direction |
| ch_rx_fifo_en | input | NUM_CH | Per-channel request for the buffer in the receive direction |
| ch_word_len | input | NUM_CH*5 | Per-channel word length in bits, channel c at bits [5c+4:5c] |
| thr_tx_ae | input | 6 | Transmit almost-empty threshold, in bytes |
| thr_rx_af | input | 6 | Receive almost-full threshold, in bytes |
| tx_push | input | 1 | Host-side transmit write request |
| tx_push_data | input | 32 | Transmit word to store |
| tx_push_ok | output | 1 | Transmit write accepted this cycle |
| tx_pop | input | 1 | Shift-engine transmit read request |
| tx_pop_data | output | 32 | Transmit word at the head |
| tx_pop_ok | output | 1 | Transmit read accepted this cycle |
| rx_push | input | 1 | Shift-engine receive write request |
| rx_push_data | input | 32 | Received word to store |
| rx_push_ok | output | 1 | Receive write accepted this cycle |
| rx_pop | input | 1 | Host-side receive read request |
| rx_pop_data | output | 32 | Receive word at the head |
| rx_pop_ok | output | 1 | Receive read accepted this cycle |
| fifo_active | output | 1 | Buffer is owned by a single enabled channel |
| owner_ch | output | 2 | Index of the owning channel |
| tx_full | output | 1 | Transmit region full |
| tx_empty | output | 1 | Transmit region empty |
| tx_almost_empty | output | 1 | Transmit free space at or above threshold plus one |
| rx_full | output | 1 | Receive region full |
| rx_empty | output | 1 | Receive region empty |
| rx_almost_full | output | 1 | Receive held bytes at or above threshold plus one |

## Verification
A wrong byte count becomes visible at the port within one word. The bench pushes until refused, so a push is accepted or refused at the wrong point and `*_full` comes up one word early or late. A wrong read or write pointer, or a wrong region base, gives wrong or out-of-order words on the pop data port in the same cycle as the bad pop. A half-split that overlaps the two directions corrupts receive words that were written while transmit words were being stored. A stale configuration snapshot leaves old bytes behind after an ownership or word-length change, so `*_empty` stays low one cycle after that change when it should rise.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int unsigned BUF_BYTES      = 64;
    localparam int unsigned WORD_BYTES_MAX = 4;
    localparam int unsigned WL_W           = 5;
    localparam int unsigned THR_W          = 6;
    localparam int unsigned ADDR_W         = $clog2(BUF_BYTES);
    localparam int unsigned CNT_W          = ADDR_W + 1;
    localparam int unsigned DATA_W         = 8 * WORD_BYTES_MAX;
    localparam int unsigned OWNER_W        = 8;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [2:0]         bpw_t;
    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [WL_W-1:0]    wlen_t;
    typedef logic [THR_W-1:0]   thr_t;

    // Ownership and layout snapshot; any difference triggers a flush
    typedef struct packed {
        logic               active;
        logic [OWNER_W-1:0] owner;
        logic               tx_on;
        logic               rx_on;
        wlen_t              wl;
    } fifo_cfg_t;

    typedef struct packed {
        addr_t base;
        cnt_t  size;
    } region_t;

    function automatic bpw_t bytes_per_word(input wlen_t wl);
        if (wl < wlen_t'(8))
            return bpw_t'(1);
        else if (wl < wlen_t'(16))
            return bpw_t'(2);
        else
            return bpw_t'(4);
    endfunction

    // Receive takes the upper half when the store is split
    function automatic region_t region_of(input logic is_rx, input logic split);
        region_t r;
        r.size = split ? cnt_t'(BUF_BYTES / 2) : cnt_t'(BUF_BYTES);
        r.base = (is_rx && split) ? addr_t'(BUF_BYTES / 2) : addr_t'(0);
        return r;
    endfunction

endpackage

// File: rtl/sfifo_owner_arb.sv
module sfifo_owner_arb
    import sfifo_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  logic [NUM_CH-1:0]      ch_en,
    input  logic [NUM_CH-1:0]      tx_req,
    input  logic [NUM_CH-1:0]      rx_req,
    input  logic [NUM_CH*WL_W-1:0] ch_wl,
    output fifo_cfg_t              cfg
);

    logic [NUM_CH-1:0] claim;
    logic              single;
    logic [OWNER_W-1:0] own;
    logic              own_en;
    logic              own_tx;
    logic              own_rx;
    wlen_t             own_wl;

    assign claim  = tx_req | rx_req;
    assign single = ($countones(claim) == 1);

    always_comb begin
        own    = '0;
        own_en = 1'b0;
        own_tx = 1'b0;
        own_rx = 1'b0;
        own_wl = '0;
        for (int c = 0; c < int'(NUM_CH); c++) begin
            if (claim[c]) begin
                own    = OWNER_W'(c);
                own_en = ch_en[c];
                own_tx = tx_req[c];
                own_rx = rx_req[c];
                own_wl = ch_wl[c*WL_W +: WL_W];
            end
        end
    end

    always_comb begin
        cfg.active = single && own_en;
        cfg.owner  = own;
        cfg.tx_on  = cfg.active && own_tx;
        cfg.rx_on  = cfg.active && own_rx;
        cfg.wl     = own_wl;
    end

endmodule

// File: rtl/sfifo_dir_ctrl.sv
module sfifo_dir_ctrl
    import sfifo_pkg::*;
#(
    parameter bit IS_TX = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            flush,
    input  logic                            enable,
    input  region_t                         region,
    input  bpw_t                            bpw,
    input  thr_t                            thr,
    input  logic                            push,
    input  logic                            pop,
    output logic                            push_ok,
    output logic                            pop_ok,
    output logic [WORD_BYTES_MAX-1:0][ADDR_W-1:0] wr_addr,
    output logic [WORD_BYTES_MAX-1:0][ADDR_W-1:0] rd_addr,
    output logic                            full,
    output logic                            empty,
    output logic                            flag
);

    addr_t wptr, rptr;
    cnt_t  count;
    cnt_t  size_m1;
    addr_t mask;
    cnt_t  free_b;
    cnt_t  thr_p1;
    cnt_t  step;
    logic [CNT_W:0] cnt_x, bpw_x, size_x;

    assign size_m1 = region.size - cnt_t'(1);
    assign mask    = size_m1[ADDR_W-1:0];
    assign step    = cnt_t'(bpw);
    assign cnt_x   = {1'b0, count};
    assign bpw_x   = {1'b0, step};
    assign size_x  = {1'b0, region.size};

    assign push_ok = enable && !flush && push && ((cnt_x + bpw_x) <= size_x);
    assign pop_ok  = enable && !flush && pop  && (cnt_x >= bpw_x);

    for (genvar k = 0; k < WORD_BYTES_MAX; k++) begin : g_lane
        assign wr_addr[k] = region.base + ((wptr + addr_t'(k)) & mask);
        assign rd_addr[k] = region.base + ((rptr + addr_t'(k)) & mask);
    end

    always_ff @(posedge clk) begin
        if (rst || flush || !enable) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok)
                wptr <= (wptr + addr_t'(bpw)) & mask;
            if (pop_ok)
                rptr <= (rptr + addr_t'(bpw)) & mask;
            count <= count + (push_ok ? step : cnt_t'(0)) - (pop_ok ? step : cnt_t'(0));
        end
    end

    assign free_b = region.size - count;
    assign thr_p1 = cnt_t'(thr) + cnt_t'(1);
    assign full   = enable && (count == region.size);
    assign empty  = !enable || (count == cnt_t'(0));

    if (IS_TX) begin : g_free_flag
        assign flag = enable && (free_b >= thr_p1);
    end else begin : g_fill_flag
        assign flag = enable && (count >= thr_p1);
    end

endmodule

// File: rtl/sfifo_byte_ram.sv
module sfifo_byte_ram
    import sfifo_pkg::*;
#(
    parameter int unsigned PORTS = 2
) (
    input  logic                                          clk,
    input  bpw_t                                          bpw,
    input  logic [PORTS-1:0]                              we,
    input  logic [PORTS-1:0][WORD_BYTES_MAX-1:0][ADDR_W-1:0] waddr,
    input  logic [PORTS-1:0][DATA_W-1:0]                  wdata,
    input  logic [PORTS-1:0][WORD_BYTES_MAX-1:0][ADDR_W-1:0] raddr,
    output logic [PORTS-1:0][DATA_W-1:0]                  rdata
);

    logic [7:0] mem [BUF_BYTES];

    // Regions of the two ports never overlap, so no write collision
    always_ff @(posedge clk) begin
        for (int p = 0; p < int'(PORTS); p++) begin
            for (int k = 0; k < int'(WORD_BYTES_MAX); k++) begin
                if (we[p] && (bpw_t'(k) < bpw))
                    mem[waddr[p][k]] <= wdata[p][8*k +: 8];
            end
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        for (genvar k = 0; k < WORD_BYTES_MAX; k++) begin : g_byte
            assign rdata[p][8*k +: 8] = (bpw_t'(k) < bpw) ? mem[raddr[p][k]] : 8'h00;
        end
    end

endmodule

// File: rtl/spi_shared_fifo.sv
module spi_shared_fifo
    import sfifo_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CH-1:0]      ch_en,
    input  logic [NUM_CH-1:0]      ch_tx_fifo_en,
    input  logic [NUM_CH-1:0]      ch_rx_fifo_en,
    input  logic [NUM_CH*WL_W-1:0] ch_word_len,
    input  logic [THR_W-1:0]       thr_tx_ae,
    input  logic [THR_W-1:0]       thr_rx_af,
    input  logic                   tx_push,
    input  logic [DATA_W-1:0]      tx_push_data,
    output logic                   tx_push_ok,
    input  logic                   tx_pop,
    output logic [DATA_W-1:0]      tx_pop_data,
    output logic                   tx_pop_ok,
    input  logic                   rx_push,
    input  logic [DATA_W-1:0]      rx_push_data,
    output logic                   rx_push_ok,
    input  logic                   rx_pop,
    output logic [DATA_W-1:0]      rx_pop_data,
    output logic                   rx_pop_ok,
    output logic                   fifo_active,
    output logic [CH_W-1:0]        owner_ch,
    output logic                   tx_full,
    output logic                   tx_empty,
    output logic                   tx_almost_empty,
    output logic                   rx_full,
    output logic                   rx_empty,
    output logic                   rx_almost_full
);

    localparam int unsigned NDIR = 2;   // index 0 transmit, 1 receive

    fifo_cfg_t cfg_now, cfg_q;
    logic      flush;
    logic      split;
    bpw_t      bpw;

    sfifo_owner_arb #(.NUM_CH(NUM_CH)) i_arb (
        .ch_en  (ch_en),
        .tx_req (ch_tx_fifo_en),
        .rx_req (ch_rx_fifo_en),
        .ch_wl  (ch_word_len),
        .cfg    (cfg_now)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else
            cfg_q <= cfg_now;
    end

    assign flush = (cfg_now != cfg_q);
    assign split = cfg_now.tx_on && cfg_now.rx_on;
    assign bpw   = bytes_per_word(cfg_now.wl);

    logic    [NDIR-1:0] d_en, d_push, d_pop, d_push_ok, d_pop_ok;
    logic    [NDIR-1:0] d_full, d_empty, d_flag;
    region_t [NDIR-1:0] d_reg;
    thr_t    [NDIR-1:0] d_thr;
    logic    [NDIR-1:0][DATA_W-1:0] d_wdata, d_rdata;
    logic    [NDIR-1:0][WORD_BYTES_MAX-1:0][ADDR_W-1:0] d_waddr, d_raddr;

    assign d_en    = {cfg_now.rx_on, cfg_now.tx_on};
    assign d_push  = {rx_push, tx_push};
    assign d_pop   = {rx_pop, tx_pop};
    assign d_thr   = {thr_rx_af, thr_tx_ae};
    assign d_wdata = {rx_push_data, tx_push_data};

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        assign d_reg[d] = region_of(d == 1, split);

        sfifo_dir_ctrl #(.IS_TX(d == 0)) i_ctrl (
            .clk     (clk),
            .rst     (rst),
            .flush   (flush),
            .enable  (d_en[d]),
            .region  (d_reg[d]),
            .bpw     (bpw),
            .thr     (d_thr[d]),
            .push    (d_push[d]),
            .pop     (d_pop[d]),
            .push_ok (d_push_ok[d]),
            .pop_ok  (d_pop_ok[d]),
            .wr_addr (d_waddr[d]),
            .rd_addr (d_raddr[d]),
            .full    (d_full[d]),
            .empty   (d_empty[d]),
            .flag    (d_flag[d])
        );
    end

    sfifo_byte_ram #(.PORTS(NDIR)) i_ram (
        .clk   (clk),
        .bpw   (bpw),
        .we    (d_push_ok),
        .waddr (d_waddr),
        .wdata (d_wdata),
        .raddr (d_raddr),
        .rdata (d_rdata)
    );

    assign tx_push_ok      = d_push_ok[0];
    assign tx_pop_ok       = d_pop_ok[0];
    assign tx_pop_data     = d_rdata[0];
    assign tx_full         = d_full[0];
    assign tx_empty        = d_empty[0];
    assign tx_almost_empty = d_flag[0];
    assign rx_push_ok      = d_push_ok[1];
    assign rx_pop_ok       = d_pop_ok[1];
    assign rx_pop_data     = d_rdata[1];
    assign rx_full         = d_full[1];
    assign rx_empty        = d_empty[1];
    assign rx_almost_full  = d_flag[1];
    assign fifo_active     = cfg_now.active;
    assign owner_ch        = cfg_now.owner[CH_W-1:0];

endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker
    import sfifo_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] ch_tx_fifo_en,
    input logic [NUM_CH-1:0] ch_rx_fifo_en,
    input logic              tx_push_ok,
    input logic              tx_pop_ok,
    input logic              rx_push_ok,
    input logic              rx_pop_ok,
    input logic [DATA_W-1:0] tx_pop_data,
    input logic              fifo_active,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              tx_almost_empty,
    input logic              rx_full,
    input logic              rx_empty,
    input logic              rx_almost_full,
    input bpw_t              word_bytes,
    input logic              tx_dir_on
);

    // R1: an active buffer has exactly one claiming channel
    a_r1_single_owner: assert property (@(posedge clk) disable iff (rst)
        fifo_active |-> ($countones(ch_tx_fifo_en | ch_rx_fifo_en) == 1));

    // R2: several claimants leave everything idle
    a_r2_conflict_idle: assert property (@(posedge clk) disable iff (rst)
        ($countones(ch_tx_fifo_en | ch_rx_fifo_en) > 1) |->
            (!fifo_active && !tx_push_ok && !rx_push_ok && !tx_pop_ok && !rx_pop_ok
             && tx_empty && rx_empty));

    // R6: no write into a full region
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (tx_full |-> !tx_push_ok) and (rx_full |-> !rx_push_ok));

    // R6: no read from an empty region
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (tx_empty |-> !tx_pop_ok) and (rx_empty |-> !rx_pop_ok));

    // R7: an accepted write leaves data behind
    a_r7_push_fills: assert property (@(posedge clk) disable iff (rst)
        (tx_push_ok && !tx_pop_ok) |=> (!tx_empty || !tx_dir_on));

    // R5: single-byte words come out with zero upper bytes
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (tx_pop_ok && (word_bytes == bpw_t'(1))) |-> (tx_pop_data[DATA_W-1:8] == '0));

    // R9: almost-full implies data present
    a_r9_af_has_data: assert property (@(posedge clk) disable iff (rst)
        rx_almost_full |-> !rx_empty);

    // R10: enable bit change empties both directions
    a_r10_flush: assert property (@(posedge clk) disable iff (rst)
        ((ch_tx_fifo_en != $past(ch_tx_fifo_en)) || (ch_rx_fifo_en != $past(ch_rx_fifo_en)))
            |=> (tx_empty && rx_empty));

    // R11: idle buffer reports empty with no flags
    a_r11_idle_status: assert property (@(posedge clk) disable iff (rst)
        !fifo_active |-> (tx_empty && rx_empty && !tx_full && !rx_full
                          && !tx_almost_empty && !rx_almost_full));

endmodule

bind spi_shared_fifo sfifo_checker #(.NUM_CH(NUM_CH)) i_sfifo_chk (
    .clk             (clk),
    .rst             (rst),
    .ch_tx_fifo_en   (ch_tx_fifo_en),
    .ch_rx_fifo_en   (ch_rx_fifo_en),
    .tx_push_ok      (tx_push_ok),
    .tx_pop_ok       (tx_pop_ok),
    .rx_push_ok      (rx_push_ok),
    .rx_pop_ok       (rx_pop_ok),
    .tx_pop_data     (tx_pop_data),
    .fifo_active     (fifo_active),
    .tx_full         (tx_full),
    .tx_empty        (tx_empty),
    .tx_almost_empty (tx_almost_empty),
    .rx_full         (rx_full),
    .rx_empty        (rx_empty),
    .rx_almost_full  (rx_almost_full),
    .word_bytes      (bpw),
    .tx_dir_on       (cfg_now.tx_on)
);

// File: tb/test_spi_shared_fifo.sv
module test_spi_shared_fifo;
    import sfifo_pkg::*;

    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0]      ch_en = '0, ch_tx_fifo_en = '0, ch_rx_fifo_en = '0;
    logic [NCH*WL_W-1:0] ch_word_len = '0;
    logic [THR_W-1:0]    thr_tx_ae = '0, thr_rx_af = 6'd63;
    logic                tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic [DATA_W-1:0]   tx_push_data = '0, rx_push_data = '0;
    logic                tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [DATA_W-1:0]   tx_pop_data, rx_pop_data;
    logic                fifo_active;
    logic [1:0]          owner_ch;
    logic                tx_full, tx_empty, tx_almost_empty;
    logic                rx_full, rx_empty, rx_almost_full;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_shared_fifo #(.NUM_CH(NCH)) i_spi_shared_fifo (.*);

    typedef struct packed {
        logic [1:0] ch;
        logic [4:0] wl;
        logic       txen;
        logic       rxen;
        logic       dir;   // 0 transmit, 1 receive
        logic [6:0] cap;   // expected capacity in words
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 5'd5,  1'b1, 1'b0, 1'b0, 7'd64},
        '{2'd1, 5'd12, 1'b0, 1'b1, 1'b1, 7'd32},
        '{2'd2, 5'd24, 1'b1, 1'b0, 1'b0, 7'd16},
        '{2'd3, 5'd8,  1'b1, 1'b1, 1'b0, 7'd16},
        '{2'd0, 5'd31, 1'b1, 1'b1, 1'b1, 7'd8},
        '{2'd1, 5'd3,  1'b1, 1'b1, 1'b1, 7'd32},
        '{2'd2, 5'd16, 1'b0, 1'b1, 1'b1, 7'd16},
        '{2'd3, 5'd7,  1'b1, 1'b1, 1'b0, 7'd32}
    };

    function automatic int exp_bytes(input logic [4:0] wl);
        if (wl < 5'd8) return 1;
        if (wl < 5'd16) return 2;
        return 4;
    endfunction

    function automatic logic [31:0] keep_bytes(input logic [31:0] d, input int nb);
        if (nb == 1) return {24'h0, d[7:0]};
        if (nb == 2) return {16'h0, d[15:0]};
        return d;
    endfunction

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic apply(input logic [3:0] en, input logic [3:0] txm, input logic [3:0] rxm,
                         input int ch, input logic [4:0] wl);
        ch_en = en;
        ch_tx_fifo_en = txm;
        ch_rx_fifo_en = rxm;
        ch_word_len = '0;
        ch_word_len[ch*WL_W +: WL_W] = wl;
        tick();
        tick();
    endtask

    task automatic set_push(input logic dir, input logic v, input logic [31:0] d);
        if (dir) begin rx_push = v; rx_push_data = d; end
        else     begin tx_push = v; tx_push_data = d; end
    endtask

    task automatic set_pop(input logic dir, input logic v);
        if (dir) rx_pop = v; else tx_pop = v;
    endtask

    function automatic logic push_ok_of(input logic dir);
        return dir ? rx_push_ok : tx_push_ok;
    endfunction

    function automatic logic pop_ok_of(input logic dir);
        return dir ? rx_pop_ok : tx_pop_ok;
    endfunction

    function automatic logic [31:0] pop_data_of(input logic dir);
        return dir ? rx_pop_data : tx_pop_data;
    endfunction

    function automatic logic full_of(input logic dir);
        return dir ? rx_full : tx_full;
    endfunction

    function automatic logic empty_of(input logic dir);
        return dir ? rx_empty : tx_empty;
    endfunction

    task automatic push_one(input logic dir, input logic [31:0] d);
        set_push(dir, 1'b1, d);
        tick();
        set_push(dir, 1'b0, '0);
    endtask

    logic [31:0] expq [64];

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        int n;
        bit going;
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        tick();

        // Reset state
        check("R11", "reset fifo_active", {31'h0, fifo_active}, 32'h0);
        check("R11", "reset tx_empty", {31'h0, tx_empty}, 32'h1);
        check("R11", "reset rx_empty", {31'h0, rx_empty}, 32'h1);
        check("R11", "reset flags", {30'h0, tx_almost_empty, rx_almost_full}, 32'h0);

        // Table walk: capacity, order, refusal
        for (int v = 0; v < 8; v++) begin
            vec_t t;
            int nb;
            t = VECS[v];
            nb = exp_bytes(t.wl);
            apply(4'(1 << t.ch), t.txen ? 4'(1 << t.ch) : 4'h0,
                  t.rxen ? 4'(1 << t.ch) : 4'h0, int'(t.ch), t.wl);
            check("R1", "active", {31'h0, fifo_active}, 32'h1);
            check("R1", "owner", {30'h0, owner_ch}, {30'h0, t.ch});
            n = 0;
            going = 1;
            while (going && n < 70) begin
                d = (32'hC3A5_1E87 ^ (32'(n) * 32'h0101_0101)) + 32'(v) * 32'h0013_0000;
                set_push(t.dir, 1'b1, d);
                #1;
                if (push_ok_of(t.dir)) begin
                    expq[n] = keep_bytes(d, nb);
                    n++;
                end else going = 0;
                tick();
            end
            set_push(t.dir, 1'b0, '0);
            tick();
            check("R4", "capacity words", 32'(n), {25'h0, t.cap});
            check("R3", "capacity bytes", 32'(n * nb), t.txen && t.rxen ? 32'd32 : 32'd64);
            check("R7", "full after fill", {31'h0, full_of(t.dir)}, 32'h1);
            set_push(t.dir, 1'b1, 32'hDEAD_BEEF);
            #1;
            check("R6", "push refused when full", {31'h0, push_ok_of(t.dir)}, 32'h0);
            tick();
            set_push(t.dir, 1'b0, '0);
            check("R6", "still full", {31'h0, full_of(t.dir)}, 32'h1);
            for (int j = 0; j < n; j++) begin
                set_pop(t.dir, 1'b1);
                #1;
                check("R5", "pop accepted", {31'h0, pop_ok_of(t.dir)}, 32'h1);
                check("R5", "pop data", pop_data_of(t.dir), expq[j]);
                tick();
            end
            set_pop(t.dir, 1'b0);
            check("R7", "empty after drain", {31'h0, empty_of(t.dir)}, 32'h1);
            set_pop(t.dir, 1'b1);
            #1;
            check("R6", "pop refused when empty", {31'h0, pop_ok_of(t.dir)}, 32'h0);
            tick();
            set_pop(t.dir, 1'b0);
        end

        // R8: transmit almost-empty against free bytes
        thr_tx_ae = 6'd59;
        apply(4'h2, 4'h2, 4'h0, 1, 5'd8);
        check("R8", "ae free64 thr59", {31'h0, tx_almost_empty}, 32'h1);
        push_one(1'b0, 32'h1111);
        push_one(1'b0, 32'h2222);
        check("R8", "ae free60 thr59", {31'h0, tx_almost_empty}, 32'h1);
        push_one(1'b0, 32'h3333);
        check("R8", "ae free58 thr59", {31'h0, tx_almost_empty}, 32'h0);
        apply(4'h2, 4'h2, 4'h2, 1, 5'd8);
        check("R8", "ae split free32 thr59", {31'h0, tx_almost_empty}, 32'h0);
        thr_tx_ae = 6'd31;
        #1;
        check("R8", "ae split free32 thr31", {31'h0, tx_almost_empty}, 32'h1);
        thr_tx_ae = 6'd0;

        // R9: receive almost-full against held bytes
        thr_rx_af = 6'd7;
        apply(4'h8, 4'h0, 4'h8, 3, 5'd20);
        push_one(1'b1, 32'hA1A2_A3A4);
        check("R9", "af held4 thr7", {31'h0, rx_almost_full}, 32'h0);
        push_one(1'b1, 32'hB1B2_B3B4);
        check("R9", "af held8 thr7", {31'h0, rx_almost_full}, 32'h1);
        check("R7", "rx not full at 8", {31'h0, rx_full}, 32'h0);

        // R10: word length change flushes
        ch_word_len[3*WL_W +: WL_W] = 5'd21;
        tick();
        check("R10", "empty after wl change", {31'h0, rx_empty}, 32'h1);
        check("R10", "af cleared after wl change", {31'h0, rx_almost_full}, 32'h0);

        // R10: re-enabling the owner flushes
        push_one(1'b1, 32'h0C0C_0C0C);
        push_one(1'b1, 32'h0D0D_0D0D);
        ch_en = 4'h0;
        tick();
        check("R11", "owner disabled inactive", {31'h0, fifo_active}, 32'h0);
        ch_en = 4'h8;
        #1;
        rx_pop = 1'b1;
        #1;
        check("R10", "pop refused in change cycle", {31'h0, rx_pop_ok}, 32'h0);
        tick();
        rx_pop = 1'b0;
        tick();
        check("R10", "empty after re-enable", {31'h0, rx_empty}, 32'h1);
        thr_rx_af = 6'd63;

        // R2: conflicting claims
        apply(4'h1, 4'h1, 4'h0, 0, 5'd8);
        push_one(1'b0, 32'h5A5A);
        ch_en = 4'h5;
        ch_rx_fifo_en = 4'h4;
        tx_push = 1'b1;
        tx_push_data = 32'h7777;
        #1;
        check("R2", "conflict inactive", {31'h0, fifo_active}, 32'h0);
        check("R2", "conflict push refused", {31'h0, tx_push_ok}, 32'h0);
        check("R2", "conflict tx_empty", {31'h0, tx_empty}, 32'h1);
        tick();
        tx_push = 1'b0;
        ch_rx_fifo_en = 4'h0;
        tick();
        tick();
        check("R1", "active after conflict cleared", {31'h0, fifo_active}, 32'h1);
        check("R10", "flushed after conflict", {31'h0, tx_empty}, 32'h1);

        // R11: claim by a disabled channel, and the unused direction
        apply(4'h0, 4'h2, 4'h0, 1, 5'd8);
        tx_push = 1'b1;
        #1;
        check("R11", "disabled owner push refused", {31'h0, tx_push_ok}, 32'h0);
        tick();
        tx_push = 1'b0;
        check("R11", "disabled owner tx_empty", {31'h0, tx_empty}, 32'h1);
        thr_rx_af = 6'd0;
        apply(4'h2, 4'h2, 4'h0, 1, 5'd8);
        rx_push = 1'b1;
        rx_push_data = 32'h9999;
        #1;
        check("R11", "unused rx push refused", {31'h0, rx_push_ok}, 32'h0);
        tick();
        rx_push = 1'b0;
        check("R11", "unused rx empty", {31'h0, rx_empty}, 32'h1);
        check("R11", "unused rx flag", {31'h0, rx_almost_full}, 32'h0);

        done = 1;
        report();
        $finish;
    end

endmodule